// File: doc/BRIEF.md
# Copy-Count Rule Monitor for a Replicated Cache

This block sits next to the tag lookup of a set-associative cache that stores every line more than once. An unmodified line is held in two ways of its set. A modified line is held in three ways. On each lookup the monitor takes the per-way tag-hit bits and each way's valid and modified flags. It counts the live matching ways and checks that the count fits the modified state of those ways. A miss, meaning no live match, is always accepted. Any other mismatch raises a machine-check request.

The request is sticky. It stays high until software or a fault handler pulses the clear input. A small syndrome records the first offending lookup: the match count and the mask of live matching ways. Later violations do not overwrite it while the request is pending. The monitor is a two-state machine. In `WATCH` it inspects every strobed lookup. A violation moves it to `TRIPPED`, which drives the request. A clear moves it from `TRIPPED` back to `WATCH`. The monitor does not repair the fault and does not deliver the interrupt.

Top module: `copy_rule_monitor`

## Requirements
- R1: After reset, `mchk_irq` is 0 and both `syn_count` and `syn_mask` are 0.
- R2: A strobed lookup with no live matching way is legal and raises nothing.
- R3: Exactly two live matches that are all unmodified are legal. Two live matches that are all modified are a violation.
- R4: Exactly three live matches that are all modified are legal. Three live matches that are all unmodified are a violation.
- R5: Live matching ways whose modified flags disagree with one another are a violation, whatever the count.
- R6: A live match count of 1, or of more than 3, is a violation whatever the flags.
- R7: A way counts as a live match only when both its `way_hit` bit and its `way_valid` bit are 1. Hit bits on invalid ways have no effect.
- R8: Inputs are ignored on cycles where `lookup_vld` is 0.
- R9: `mchk_irq` rises on the clock edge that samples the violating lookup, so it is visible one cycle after that lookup. It then stays high until a cycle with `irq_clr` high, and it is low from the following cycle.
- R10: The syndrome holds the count and the live-match mask (bit i = way i) of the first violation. It is not changed by later lookups while `mchk_irq` is high.
- R11: If a violating lookup arrives in the same cycle as a clear of a pending request, the clear wins and the new violation is dropped. A clear while nothing is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_vld | input | 1 | Qualifies a lookup in this cycle |
| way_hit | input | NUM_WAYS | Tag-compare hit per way |
| way_valid | input | NUM_WAYS | Valid flag per way |
| way_dirty | input | NUM_WAYS | Modified flag per way |
| irq_clr | input | 1 | Clears a pending machine-check request |
| mchk_irq | output | 1 | Sticky machine-check request |
| syn_count | output | $clog2(NUM_WAYS+1) | Live match count of the first violation |
| syn_mask | output | NUM_WAYS | Live matching ways of the first violation |

## Verification
Every result has one register between the inputs and the outputs. A lookup or clear driven before a rising edge shows on `mchk_irq` and the syndrome after that edge. The bench drives inputs at falling edges and samples one falling edge later, so each check lands exactly one cycle after its stimulus. The sweep covers every combination of hit, valid and modified bits for four ways. After each combination the bench clears any pending request and confirms the output is low a cycle later, so no combination leaks into the next one.

// File: rtl/copy_rule_pkg.sv
package copy_rule_pkg;
    typedef enum logic [0:0] {
        ST_WATCH   = 1'b0,
        ST_TRIPPED = 1'b1
    } mon_state_e;
endpackage

// File: rtl/copy_match_census.sv
// Counts live matching ways and summarises their modified flags.
module copy_match_census #(
    parameter int NUM_WAYS = 8,
    parameter int CNT_W    = $clog2(NUM_WAYS + 1)
) (
    input  logic [NUM_WAYS-1:0] way_hit,
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [NUM_WAYS-1:0] way_dirty,
    output logic [NUM_WAYS-1:0] live_mask,
    output logic [CNT_W-1:0]    live_count,
    output logic                all_clean,
    output logic                all_dirty
);
    logic [NUM_WAYS-1:0] live_dirty;
    logic [NUM_WAYS-1:0] live_clean;

    genvar g;
    generate
        for (g = 0; g < NUM_WAYS; g++) begin : g_way
            assign live_mask[g]  = way_hit[g] & way_valid[g];
            assign live_dirty[g] = live_mask[g] & way_dirty[g];
            assign live_clean[g] = live_mask[g] & ~way_dirty[g];
        end
    endgenerate

    always_comb begin
        live_count = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            live_count = live_count + CNT_W'(live_mask[i]);
        end
    end

    assign all_clean = (live_dirty == '0);
    assign all_dirty = (live_clean == '0);
endmodule

// File: rtl/copy_rule_judge.sv
// Decides whether a census is allowed by the two-copy / three-copy rule.
module copy_rule_judge #(
    parameter int CNT_W = 4
) (
    input  logic             check_en,
    input  logic [CNT_W-1:0] live_count,
    input  logic             all_clean,
    input  logic             all_dirty,
    output logic             violation
);
    localparam logic [CNT_W-1:0] CLEAN_COPIES = CNT_W'(2);
    localparam logic [CNT_W-1:0] DIRTY_COPIES = CNT_W'(3);

    logic legal;

    always_comb begin
        legal = (live_count == '0)
             || ((live_count == CLEAN_COPIES) && all_clean)
             || ((live_count == DIRTY_COPIES) && all_dirty);
        violation = check_en && !legal;
    end
endmodule

// File: rtl/copy_rule_monitor.sv
module copy_rule_monitor #(
    parameter int NUM_WAYS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lookup_vld,
    input  logic [NUM_WAYS-1:0]               way_hit,
    input  logic [NUM_WAYS-1:0]               way_valid,
    input  logic [NUM_WAYS-1:0]               way_dirty,
    input  logic                              irq_clr,
    output logic                              mchk_irq,
    output logic [$clog2(NUM_WAYS+1)-1:0]     syn_count,
    output logic [NUM_WAYS-1:0]               syn_mask
);
    import copy_rule_pkg::*;

    localparam int CNT_W = $clog2(NUM_WAYS + 1);

    logic [NUM_WAYS-1:0] live_mask;
    logic [CNT_W-1:0]    live_count;
    logic                all_clean;
    logic                all_dirty;
    logic                violation;
    logic                capture;

    mon_state_e state_q, state_d;

    copy_match_census #(
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W)
    ) u_census (
        .way_hit    (way_hit),
        .way_valid  (way_valid),
        .way_dirty  (way_dirty),
        .live_mask  (live_mask),
        .live_count (live_count),
        .all_clean  (all_clean),
        .all_dirty  (all_dirty)
    );

    copy_rule_judge #(
        .CNT_W (CNT_W)
    ) u_judge (
        .check_en   (lookup_vld),
        .live_count (live_count),
        .all_clean  (all_clean),
        .all_dirty  (all_dirty),
        .violation  (violation)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH:   if (violation) state_d = ST_TRIPPED;
            ST_TRIPPED: if (irq_clr)   state_d = ST_WATCH;
            default:                   state_d = ST_WATCH;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    // Outputs: request follows state, syndrome latched on the first violation
    assign capture  = (state_q == ST_WATCH) && violation;
    assign mchk_irq = (state_q == ST_TRIPPED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_count <= '0;
            syn_mask  <= '0;
        end else if (capture) begin
            syn_count <= live_count;
            syn_mask  <= live_mask;
        end
    end
endmodule

// File: rtl/copy_rule_monitor_sva.sv
module copy_rule_monitor_sva #(
    parameter int NUM_WAYS = 8,
    parameter int CNT_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lookup_vld,
    input logic [NUM_WAYS-1:0] way_hit,
    input logic [NUM_WAYS-1:0] way_valid,
    input logic                irq_clr,
    input logic                mchk_irq,
    input logic [CNT_W-1:0]    syn_count,
    input logic [NUM_WAYS-1:0] syn_mask
);
    AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mchk_irq && lookup_vld && ((way_hit & way_valid) == '0)) |=> !mchk_irq); // R2
    AST_SINGLE_COPY_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mchk_irq && lookup_vld && ($countones(way_hit & way_valid) == 1)) |=> mchk_irq); // R6
    AST_IDLE_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mchk_irq && !lookup_vld) |=> !mchk_irq); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_irq && !irq_clr) |=> mchk_irq); // R9
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_irq && irq_clr) |=> !mchk_irq); // R11
    AST_SYNDROME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_irq && !irq_clr) |=> ($stable(syn_count) && $stable(syn_mask))); // R10
endmodule

bind copy_rule_monitor copy_rule_monitor_sva #(
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_vld (lookup_vld),
    .way_hit    (way_hit),
    .way_valid  (way_valid),
    .irq_clr    (irq_clr),
    .mchk_irq   (mchk_irq),
    .syn_count  (syn_count),
    .syn_mask   (syn_mask)
);

// File: tb/copy_rule_monitor_bench.sv
`timescale 1ns/1ps
module copy_rule_monitor_bench;
    localparam int W  = 4;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lookup_vld;
    logic [W-1:0]  way_hit, way_valid, way_dirty;
    logic          irq_clr;
    logic          mchk_irq;
    logic [CW-1:0] syn_count;
    logic [W-1:0]  syn_mask;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    copy_rule_monitor #(.NUM_WAYS(W)) u_copy_rule_monitor (
        .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld),
        .way_hit(way_hit), .way_valid(way_valid), .way_dirty(way_dirty),
        .irq_clr(irq_clr), .mchk_irq(mchk_irq),
        .syn_count(syn_count), .syn_mask(syn_mask)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [W-1:0] h, input logic [W-1:0] v,
                          input logic [W-1:0] d, input logic clr);
        lookup_vld = 1'b1; way_hit = h; way_valid = v; way_dirty = d; irq_clr = clr;
        @(negedge clk);
        lookup_vld = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic clear_pulse();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    function automatic int expect_bad(input logic [W-1:0] m, input logic [W-1:0] d);
        int c = 0;
        for (int i = 0; i < W; i++) c += m[i];
        if (c == 0) return 0;
        if (c == 2 && (m & d) == '0) return 0;
        if (c == 3 && (m & ~d) == '0) return 0;
        return 1;
    endfunction

    function automatic string tag_of(input logic [W-1:0] m, input logic [W-1:0] d);
        int c = 0;
        for (int i = 0; i < W; i++) c += m[i];
        if (c == 0) return "R2";
        if (c == 1 || c > 3) return "R6";
        if ((m & d) != '0 && (m & ~d) != '0) return "R5";
        return (c == 2) ? "R3" : "R4";
    endfunction

    initial begin
        rst_n = 1'b0; lookup_vld = 1'b0; irq_clr = 1'b0;
        way_hit = '0; way_valid = '0; way_dirty = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", mchk_irq, 0);
        chk("R1 count", syn_count, 0);
        chk("R1 mask", syn_mask, 0);

        // Exhaustive sweep (R2..R7, R9, R10)
        for (int h = 0; h < (1 << W); h++) begin
            for (int v = 0; v < (1 << W); v++) begin
                for (int d = 0; d < (1 << W); d++) begin
                    logic [W-1:0] m;
                    int bad, cnt;
                    m = W'(h) & W'(v);
                    bad = expect_bad(m, W'(d));
                    cnt = 0;
                    for (int i = 0; i < W; i++) cnt += m[i];
                    lookup(W'(h), W'(v), W'(d), 1'b0);
                    chk({tag_of(m, W'(d)), " R7 verdict"}, mchk_irq, bad);
                    if (bad != 0) begin
                        chk("R10 count", syn_count, cnt);
                        chk("R10 mask", syn_mask, m);
                        clear_pulse();
                        chk("R9 cleared", mchk_irq, 0);
                    end
                end
            end
        end

        // R8: strobe low ignored
        lookup_vld = 1'b0; way_hit = 4'b0001; way_valid = 4'b1111; way_dirty = 4'b0000;
        @(negedge clk);
        chk("R8 no strobe", mchk_irq, 0);

        // R7: hit on invalid ways only
        lookup(4'b1111, 4'b0011, 4'b0000, 1'b0);
        chk("R7 invalid hits ignored", mchk_irq, 0);

        // R9/R10: sticky and first syndrome kept
        lookup(4'b0100, 4'b1111, 4'b0000, 1'b0);
        chk("R9 raise", mchk_irq, 1);
        lookup(4'b1111, 4'b1111, 4'b1111, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9 sticky", mchk_irq, 1);
        chk("R10 first count", syn_count, 1);
        chk("R10 first mask", syn_mask, 4'b0100);

        // R11: clear wins over simultaneous violation
        lookup(4'b1000, 4'b1111, 4'b0000, 1'b1);
        chk("R11 clear wins", mchk_irq, 0);
        chk("R11 syndrome kept", syn_mask, 4'b0100);
        clear_pulse();
        chk("R11 idle clear", mchk_irq, 0);
        lookup(4'b0111, 4'b1111, 4'b0111, 1'b0);
        chk("R4 legal after clear", mchk_irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule